// File: doc/BRIEF.md
# Two-wire handshake bit receiver

This block is the receiving end of a two-line, open-drain link on which every bit is carried by a full four-phase handshake. Both lines idle high. The sender signals a bit by pulling one of the lines low. The receiver answers by pulling the other line low. When the sender lets its line go, the receiver releases its answer, and both lines return to idle before the next bit starts. No clock travels with the data, so any rate that each side can follow will work.

Bits are grouped into nine-bit frames. A frame opens with a sync bit of 1 and is followed by eight data bits, most significant first. A run of nine zero bits cannot occur inside normal traffic, so the link uses it as a marker. The byte that follows a marker is a new context value and not ordinary data. The receiver rebuilds the frames, presents each byte for one cycle with a flag that tells context bytes apart from data, and reports a line error when both lines are pulled at once.

Top module: `twh_rx`

## Requirements
- R1: When the zero line (`zero_ln_i`) goes low on its own, the block takes a 0 bit and acknowledges by asserting `pull_one_o`, which pulls the one line low.
- R2: When the one line (`one_ln_i`) goes low on its own, the block takes a 1 bit and acknowledges by asserting `pull_zero_o`.
- R3: The acknowledge stays asserted while the sender's line is low. It is released only after that line has come back high, and no new bit is taken until both lines are seen high again.
- R4: `pull_zero_o` and `pull_one_o` are never asserted in the same cycle.
- R5: A frame is a 1 sync bit followed by eight data bits, MSB first. The byte appears on `rx_byte_o` with `rx_valid_o` high for exactly one cycle, and `rx_byte_o` keeps that value until the next byte is delivered.
- R6: Zero bits that arrive while no frame is open are skipped. A frame opens only on a 1 bit.
- R7: Nine consecutive 0 bits form a context marker. The next delivered byte carries `rx_ctx_o` high, only in its valid cycle. Later bytes carry `rx_ctx_o` low.
- R8: If both lines are seen low when a bit starts, `rx_err_o` pulses for one cycle, no acknowledge is given, any partly received frame is dropped, and the block waits until both lines are high.
- R9: Each line passes through a two-flop synchronizer, and a level counts only after it has been stable for one further cycle. A low pulse one clock long is ignored.
- R10: After reset, both acknowledges are released, `rx_valid_o`, `rx_ctx_o` and `rx_err_o` are low, no frame is open and no context is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_ln_i | input | 1 | Level seen on the line whose low state signals a 0 bit |
| one_ln_i | input | 1 | Level seen on the line whose low state signals a 1 bit |
| pull_zero_o | output | 1 | 1 pulls the zero line low (acknowledge of a 1 bit) |
| pull_one_o | output | 1 | 1 pulls the one line low (acknowledge of a 0 bit) |
| rx_byte_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe: new byte on rx_byte_o |
| rx_ctx_o | output | 1 | Byte in this valid cycle is a context value |
| rx_err_o | output | 1 | One-cycle strobe: both lines were low at the start of a bit |

## Verification
The assertions take for granted that the sender keeps to the handshake. It does not pull its line low again before the acknowledge has been released. Between bits it leaves both lines high for several cycles, long enough for the idle level to pass through the synchronizer. It pulls both lines together only when a line fault is being provoked. The bench's sender task waits for the acknowledge, holds its line for a few more cycles, and then inserts a six-cycle idle gap before every bit. Single-cycle glitches and the both-low fault are the only stimuli outside the normal handshake, and neither happens while an acknowledge is pending.

// File: rtl/twh_pkg.sv
package twh_pkg;

  // Handshake sequencer states
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,  // waiting for a data line to fall
    HS_ACK_Z = 2'd1,  // acknowledging a 0 bit on the one line
    HS_ACK_O = 2'd2,  // acknowledging a 1 bit on the zero line
    HS_WAIT  = 2'd3   // waiting for both lines to be seen idle
  } hs_state_e;

  // Bit index of each line inside the filtered line vector
  localparam int LN_ZERO = 0;
  localparam int LN_ONE  = 1;
  localparam int LN_CNT  = 2;

endpackage

// File: rtl/twh_line_filter.sv
module twh_line_filter #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] clean_o
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              hist;
    logic              level;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        hist  <= 1'b1;
        level <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        hist  <= chain[STAGES-1];
        // take the synchronized level only once it has held for a cycle
        if (chain[STAGES-1] == hist) level <= hist;
      end
    end

    assign clean_o[g] = level;
  end

endmodule

// File: rtl/twh_hs_fsm.sv
module twh_hs_fsm
  import twh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic zero_hi_i,
  input  logic one_hi_i,
  output logic pull_zero_o,
  output logic pull_one_o,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic err_o
);

  hs_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= HS_IDLE;
      pull_zero_o <= 1'b0;
      pull_one_o  <= 1'b0;
      bit_stb_o   <= 1'b0;
      bit_val_o   <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      bit_stb_o <= 1'b0;
      err_o     <= 1'b0;
      unique case (st)
        HS_IDLE: begin
          if (!zero_hi_i && !one_hi_i) begin
            err_o <= 1'b1;
            st    <= HS_WAIT;
          end else if (!zero_hi_i) begin
            bit_stb_o  <= 1'b1;
            bit_val_o  <= 1'b0;
            pull_one_o <= 1'b1;
            st         <= HS_ACK_Z;
          end else if (!one_hi_i) begin
            bit_stb_o   <= 1'b1;
            bit_val_o   <= 1'b1;
            pull_zero_o <= 1'b1;
            st          <= HS_ACK_O;
          end
        end
        HS_ACK_Z: begin
          if (zero_hi_i) begin
            pull_one_o <= 1'b0;
            st         <= HS_WAIT;
          end
        end
        HS_ACK_O: begin
          if (one_hi_i) begin
            pull_zero_o <= 1'b0;
            st          <= HS_WAIT;
          end
        end
        HS_WAIT: begin
          if (zero_hi_i && one_hi_i) st <= HS_IDLE;
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twh_deser.sv
module twh_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              abort_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              byte_ctx_o
);

  localparam int FRAME_BITS = DATA_W + 1;
  localparam int CNT_W      = $clog2(DATA_W);
  localparam int RUN_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(FRAME_BITS);

  logic              in_frame;
  logic [CNT_W-1:0]  data_cnt;
  logic [DATA_W-1:0] shreg;
  logic [RUN_W-1:0]  zero_run;
  logic [RUN_W-1:0]  run_nxt;
  logic              ctx_pend;
  logic [DATA_W-1:0] shreg_nxt;

  always_comb begin
    if (bit_val_i)               run_nxt = '0;
    else if (zero_run == RUN_MAX) run_nxt = zero_run;
    else                         run_nxt = zero_run + 1'b1;
    shreg_nxt = {shreg[DATA_W-2:0], bit_val_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      data_cnt   <= '0;
      shreg      <= '0;
      zero_run   <= '0;
      ctx_pend   <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      byte_ctx_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      byte_ctx_o <= 1'b0;
      if (abort_i) begin
        in_frame <= 1'b0;
        data_cnt <= '0;
        zero_run <= '0;
      end else if (bit_stb_i) begin
        zero_run <= run_nxt;
        if (run_nxt == RUN_MAX) begin
          // marker: realign and mark the next byte as a context value
          in_frame <= 1'b0;
          data_cnt <= '0;
          ctx_pend <= 1'b1;
        end else if (!in_frame) begin
          if (bit_val_i) begin
            in_frame <= 1'b1;
            data_cnt <= '0;
          end
        end else begin
          shreg <= shreg_nxt;
          if (data_cnt == LAST_IDX) begin
            in_frame   <= 1'b0;
            data_cnt   <= '0;
            byte_o     <= shreg_nxt;
            byte_vld_o <= 1'b1;
            byte_ctx_o <= ctx_pend;
            ctx_pend   <= 1'b0;
          end else begin
            data_cnt <= data_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/twh_rx.sv
module twh_rx
  import twh_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_ln_i,
  input  logic              one_ln_i,
  output logic              pull_zero_o,
  output logic              pull_one_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_ctx_o,
  output logic              rx_err_o
);

  logic [LN_CNT-1:0] raw_ln;
  logic [LN_CNT-1:0] clean_ln;
  logic              bit_stb;
  logic              bit_val;
  logic              line_err;

  assign raw_ln[LN_ZERO] = zero_ln_i;
  assign raw_ln[LN_ONE]  = one_ln_i;

  twh_line_filter #(
    .W      (LN_CNT),
    .STAGES (SYNC_STAGES)
  ) u_filt (
    .clk     (clk),
    .rst     (rst),
    .raw_i   (raw_ln),
    .clean_o (clean_ln)
  );

  twh_hs_fsm u_hs (
    .clk         (clk),
    .rst         (rst),
    .zero_hi_i   (clean_ln[LN_ZERO]),
    .one_hi_i    (clean_ln[LN_ONE]),
    .pull_zero_o (pull_zero_o),
    .pull_one_o  (pull_one_o),
    .bit_stb_o   (bit_stb),
    .bit_val_o   (bit_val),
    .err_o       (line_err)
  );

  twh_deser #(
    .DATA_W (DATA_W)
  ) u_deser (
    .clk        (clk),
    .rst        (rst),
    .bit_stb_i  (bit_stb),
    .bit_val_i  (bit_val),
    .abort_i    (line_err),
    .byte_o     (rx_byte_o),
    .byte_vld_o (rx_valid_o),
    .byte_ctx_o (rx_ctx_o)
  );

  assign rx_err_o = line_err;

endmodule

// File: rtl/twh_rx_chk.sv
module twh_rx_chk (
  input logic clk,
  input logic rst,
  input logic zero_ln_i,
  input logic one_ln_i,
  input logic pull_zero_o,
  input logic pull_one_o,
  input logic rx_valid_o,
  input logic rx_ctx_o,
  input logic rx_err_o
);

  a_r4_acks_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pull_zero_o && pull_one_o));

  // R3: an acknowledge is not dropped while the sender still holds its line
  a_r3_hold_ack_zero: assert property (@(posedge clk) disable iff (rst)
    (pull_one_o && !zero_ln_i) |=> pull_one_o);

  a_r3_hold_ack_one: assert property (@(posedge clk) disable iff (rst)
    (pull_zero_o && !one_ln_i) |=> pull_zero_o);

  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  a_r7_ctx_with_valid: assert property (@(posedge clk) disable iff (rst)
    rx_ctx_o |-> rx_valid_o);

  a_r8_err_no_ack: assert property (@(posedge clk) disable iff (rst)
    rx_err_o |-> (!pull_zero_o && !pull_one_o));

endmodule

bind twh_rx twh_rx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .zero_ln_i   (zero_ln_i),
  .one_ln_i    (one_ln_i),
  .pull_zero_o (pull_zero_o),
  .pull_one_o  (pull_one_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ctx_o    (rx_ctx_o),
  .rx_err_o    (rx_err_o)
);

// File: tb/twh_rx_tb_top.sv
module twh_rx_tb_top;

  localparam int DW  = 8;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snd_zero = 1'b0;
  logic snd_one  = 1'b0;
  logic zero_ln, one_ln;
  logic pull_zero, pull_one;
  logic [DW-1:0] rx_byte;
  logic rx_valid, rx_ctx, rx_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_bit = -1;
  int err_seen = 0;
  bit mon_on = 1'b0;
  logic [DW:0] exp_q[$];

  always #10 clk = ~clk;

  // wired-AND of the open-drain lines
  assign zero_ln = ~(snd_zero | pull_zero);
  assign one_ln  = ~(snd_one  | pull_one);

  twh_rx #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .zero_ln_i   (zero_ln),
    .one_ln_i    (one_ln),
    .pull_zero_o (pull_zero),
    .pull_one_o  (pull_one),
    .rx_byte_o   (rx_byte),
    .rx_valid_o  (rx_valid),
    .rx_ctx_o    (rx_ctx),
    .rx_err_o    (rx_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (mon_on) begin
      chk(!(pull_zero && pull_one), "R4 both acks", {pull_zero, pull_one}, 0);
      if (pull_one)  chk(cur_bit == 0, "R1/R8/R9 ack on one line without 0 bit", cur_bit, 0);
      if (pull_zero) chk(cur_bit == 1, "R2/R8/R9 ack on zero line without 1 bit", cur_bit, 1);
      if (!rx_valid) chk(!rx_ctx, "R7 ctx outside valid", rx_ctx, 0);
      if (rx_err) err_seen++;
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R6 unexpected byte", rx_byte, 0);
        end else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          chk(rx_byte == e[DW-1:0], "R5 byte value", rx_byte, e[DW-1:0]);
          chk(rx_ctx == e[DW], "R7 ctx flag", rx_ctx, e[DW]);
        end
      end
    end
  end

  task automatic idle_gap();
    int t;
    t = 0;
    while (!(zero_ln && one_ln) && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(zero_ln && one_ln, "R3 lines back to idle", {zero_ln, one_ln}, 3);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    int t;
    idle_gap();
    #1;
    cur_bit = b ? 1 : 0;
    if (b) snd_one = 1'b1; else snd_zero = 1'b1;
    t = 0;
    while (!(b ? pull_zero : pull_one) && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (b) chk(pull_zero, "R2 ack of 1 bit on zero line", pull_zero, 1);
    else   chk(pull_one, "R1 ack of 0 bit on one line", pull_one, 1);
    repeat (3) @(negedge clk);
    chk(b ? pull_zero : pull_one, "R3 ack held while line low", b ? pull_zero : pull_one, 1);
    #1;
    snd_zero = 1'b0;
    snd_one  = 1'b0;
    t = 0;
    while ((pull_zero || pull_one) && t < 50) begin
      @(negedge clk);
      t++;
    end
    chk(!pull_zero && !pull_one, "R3 ack released", {pull_zero, pull_one}, 0);
    cur_bit = -1;
  endtask

  task automatic send_frame(input logic [DW-1:0] v, input bit ctx);
    exp_q.push_back({ctx, v});
    send_bit(1'b1);
    for (int i = DW - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_marker();
    for (int i = 0; i < DW + 1; i++) send_bit(1'b0);
  endtask

  task automatic drain(input string tag);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic glitch(input bit on_one);
    @(negedge clk);
    #1;
    if (on_one) snd_one = 1'b1; else snd_zero = 1'b1;
    @(negedge clk);
    #1;
    snd_one  = 1'b0;
    snd_zero = 1'b0;
    repeat (10) @(negedge clk);
    chk(!pull_zero && !pull_one, "R9 glitch not acknowledged", {pull_zero, pull_one}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!pull_zero && !pull_one, "R10 acks released in reset", {pull_zero, pull_one}, 0);
    chk(!rx_valid && !rx_ctx && !rx_err, "R10 strobes low in reset", {rx_valid, rx_ctx, rx_err}, 0);
    @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!pull_zero && !pull_one && !rx_valid && !rx_err, "R10 idle after reset",
        {pull_zero, pull_one, rx_valid, rx_err}, 0);
    mon_on = 1'b1;

    // R5 plain frames
    send_frame(8'hA5, 1'b0);
    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b0);
    drain("R5 plain frames delivered");

    // R6 stray zeros before a frame
    send_bit(1'b0);
    send_bit(1'b0);
    send_frame(8'h81, 1'b0);
    drain("R6 zeros skipped");

    // R7 context marker then data
    send_marker();
    send_frame(8'h10, 1'b1);
    send_frame(8'h02, 1'b0);
    send_frame(8'h03, 1'b0);
    drain("R7 context sequence");

    // R7 marker right after a byte ending in zeros
    send_frame(8'h80, 1'b0);
    send_marker();
    send_frame(8'h7E, 1'b1);
    drain("R7 marker after trailing zeros");

    // R8 line fault aborts partial frame
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    idle_gap();
    #1;
    snd_zero = 1'b1;
    snd_one  = 1'b1;
    repeat (8) @(negedge clk);
    chk(err_seen == 1, "R8 error pulse", err_seen, 1);
    chk(!pull_zero && !pull_one, "R8 no ack on fault", {pull_zero, pull_one}, 0);
    #1;
    snd_zero = 1'b0;
    snd_one  = 1'b0;
    send_frame(8'h5A, 1'b0);
    drain("R8 partial frame dropped");

    // R9 one-cycle glitches
    glitch(1'b0);
    glitch(1'b1);
    send_frame(8'hC3, 1'b0);
    drain("R9 frame after glitches");
    chk(rx_byte == 8'hC3, "R5 byte held after valid", rx_byte, 8'hC3);
    chk(err_seen == 1, "R8 no further errors", err_seen, 1);

    mon_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule